// File: doc/BRIEF.md
# Status Byte Service Request Unit

This block assembles an instrument-style status byte from four summary flags supplied by neighbouring status registers: an operation summary, an event-status summary, a message-available flag and a questionable summary. An 8-bit enable mask selects which of these flags may raise a service request. The OR of the flags that are both set and enabled forms a master summary bit.

A rising master summary also latches a request-for-service flag. That flag drives an active-low service-request pin. It stays set until a serial poll consumes it.

Two read paths present the byte. The plain status output always carries the master summary in bit 6, and reading it changes nothing. The serial-poll output carries the latched request flag in bit 6 instead. A one-cycle poll strobe clears that flag at the next clock edge, and the byte presented in the strobe cycle still shows the flag as it was. The poll strobe has no effect on the master summary. The mask can be written and read back. Every pin is a plain control or status signal, so there is no back-pressure at the edge of the block.

Top module: `srq_status_unit`

## Requirements
- R1: Both output bytes place the operation summary in bit 7, the event-status summary in bit 5, message-available in bit 4 and the questionable summary in bit 3. Bits 2 to 0 always read 0.
- R2: A mask write stores the 8-bit data at the clock edge. From the next cycle, the mask readback equals the written value with bit 6 forced to 0.
- R3: The master summary is the OR of each status bit 7, 5, 4 and 3 ANDed with the mask bit at the same position. Mask bits 6 and 2 to 0 have no effect on it.
- R4: The status output shows the master summary in bit 6, and reading it clears nothing.
- R5: The request flag is set at the clock edge where the master summary is 1 and was 0 at the previous edge.
- R6: The poll output equals the status output except that bit 6 shows the request flag. A poll strobe clears the flag at that edge and leaves the master summary unchanged.
- R7: While the master summary stays high after a poll, the request flag is not set again. The flag is set again only after the summary falls and then rises.
- R8: The service-request output is low exactly when the request flag is 1.
- R9: A synchronous reset clears the mask and the request flag to 0.
- R10: When a poll strobe falls on the same edge as a master summary rise, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_sum_i | input | 1 | Operation status summary |
| evt_sum_i | input | 1 | Event-status summary |
| msg_avail_i | input | 1 | Message available |
| qst_sum_i | input | 1 | Questionable status summary |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | Mask write data |
| mask_rdata_o | output | 8 | Mask readback (bit 6 reads 0) |
| status_o | output | 8 | Status byte, bit 6 = master summary |
| poll_i | input | 1 | Serial-poll strobe |
| poll_byte_o | output | 8 | Poll byte, bit 6 = request flag |
| srq_n_o | output | 1 | Service request, active low |

## Verification
The hardest case to reach is a poll strobe landing on the very edge where the master summary rises. A mask write that enables a flag already held high makes the summary rise one cycle after the write. The bench raises the poll strobe in exactly that cycle, so the two collide.

A second hard case is a summary that stays high across a poll. The bench holds a source flag high through a poll, adds a second source, and then drops and raises the summary to show that the flag re-arms only on a new rise.

A behavioural model updated on every edge predicts all outputs each cycle.

// File: rtl/srq_pkg.sv
package srq_pkg;
  localparam int SB_W    = 8;
  localparam int OP_POS  = 7;
  localparam int RQ_POS  = 6;
  localparam int EVT_POS = 5;
  localparam int MSG_POS = 4;
  localparam int QST_POS = 3;
  localparam int NSRC    = 4;
  typedef logic [SB_W-1:0] sbyte_t;
endpackage

// File: rtl/srq_mask_reg.sv
module srq_mask_reg #(
  parameter int W    = 8,
  parameter int HOLE = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  localparam logic [W-1:0] KEEP = ~(W'(1) << HOLE);

  logic [W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst)       mask_q <= '0;
    else if (wr_i) mask_q <= wdata_i & KEEP;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/srq_summary.sv
module srq_summary
  import srq_pkg::*;
(
  input  logic [NSRC-1:0] src_i,   // {op, evt, msg, qst}
  input  sbyte_t          mask_i,
  output sbyte_t          raw_o,   // bit 6 left at 0
  output logic            mss_o
);
  localparam int POS [NSRC] = '{QST_POS, MSG_POS, EVT_POS, OP_POS};

  sbyte_t  raw;
  logic [NSRC-1:0] hit;

  always_comb begin
    raw = '0;
    for (int i = 0; i < NSRC; i++) raw[POS[i]] = src_i[i];
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_hit
    assign hit[g] = src_i[g] & mask_i[POS[g]];
  end

  assign raw_o = raw;
  assign mss_o = |hit;
endmodule

// File: rtl/srq_request_latch.sv
module srq_request_latch (
  input  logic clk,
  input  logic rst,
  input  logic mss_i,
  input  logic poll_i,
  output logic rqs_o
);
  logic mss_q;
  logic rqs_q;
  logic rise;

  assign rise = mss_i & ~mss_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mss_q <= 1'b0;
      rqs_q <= 1'b0;
    end else begin
      mss_q <= mss_i;
      if (rise)        rqs_q <= 1'b1;   // a new rise beats a poll on the same edge
      else if (poll_i) rqs_q <= 1'b0;
    end
  end

  assign rqs_o = rqs_q;
endmodule

// File: rtl/srq_status_unit.sv
module srq_status_unit
  import srq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            op_sum_i,
  input  logic            evt_sum_i,
  input  logic            msg_avail_i,
  input  logic            qst_sum_i,
  input  logic            mask_wr_i,
  input  logic [SB_W-1:0] mask_wdata_i,
  output logic [SB_W-1:0] mask_rdata_o,
  output logic [SB_W-1:0] status_o,
  input  logic            poll_i,
  output logic [SB_W-1:0] poll_byte_o,
  output logic            srq_n_o
);
  sbyte_t mask;
  sbyte_t raw;
  logic   mss;
  logic   rqs;

  srq_mask_reg #(.W(SB_W), .HOLE(RQ_POS)) u_mask (
    .clk(clk), .rst(rst), .wr_i(mask_wr_i), .wdata_i(mask_wdata_i), .mask_o(mask)
  );

  srq_summary u_sum (
    .src_i({op_sum_i, evt_sum_i, msg_avail_i, qst_sum_i}),
    .mask_i(mask), .raw_o(raw), .mss_o(mss)
  );

  srq_request_latch u_req (
    .clk(clk), .rst(rst), .mss_i(mss), .poll_i(poll_i), .rqs_o(rqs)
  );

  always_comb begin
    status_o            = raw;
    status_o[RQ_POS]    = mss;
    poll_byte_o         = raw;
    poll_byte_o[RQ_POS] = rqs;
  end

  assign mask_rdata_o = mask;
  assign srq_n_o      = ~rqs;
endmodule

// File: rtl/srq_status_unit_chk.sv
module srq_status_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       mask_wr_i,
  input logic [7:0] mask_wdata_i,
  input logic [7:0] mask_rdata_o,
  input logic [7:0] status_o,
  input logic       poll_i,
  input logic [7:0] poll_byte_o,
  input logic       srq_n_o
);
  assert_low_bits_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (status_o[2:0] == 3'b000) && (poll_byte_o[2:0] == 3'b000));

  assert_mask_write_R2: assert property (@(posedge clk) disable iff (rst)
    mask_wr_i |=> (mask_rdata_o == ($past(mask_wdata_i) & 8'hBF)));

  assert_zero_mask_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (mask_rdata_o == 8'h00) |-> !status_o[6]);

  assert_rise_sets_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[6]) |=> !srq_n_o);

  assert_poll_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (poll_i && !$rose(status_o[6])) |=> srq_n_o);

  assert_poll_fields_R6: assert property (@(posedge clk) disable iff (rst)
    {poll_byte_o[7], poll_byte_o[5:0]} == {status_o[7], status_o[5:0]});

  assert_no_rearm_R7: assert property (@(posedge clk) disable iff (rst)
    (srq_n_o && !$rose(status_o[6])) |=> srq_n_o);

  assert_pin_tracks_R8: assert property (@(posedge clk) disable iff (rst)
    poll_byte_o[6] == !srq_n_o);

  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (mask_rdata_o == 8'h00) && srq_n_o);
endmodule

bind srq_status_unit srq_status_unit_chk u_chk (.*);

// File: tb/srq_status_unit_tb.sv
`timescale 1ns/1ps
module srq_status_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op = 0, evt = 0, mav = 0, qst = 0;
  logic       wr = 0, poll = 0;
  logic [7:0] wdata = '0;
  logic [7:0] mask_rd, status, pbyte;
  logic       srq_n;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [7:0] m_mask = '0;
  logic       m_rqs  = 1'b0;
  logic       m_prev = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  srq_status_unit u_dut (
    .clk(clk), .rst(rst), .op_sum_i(op), .evt_sum_i(evt), .msg_avail_i(mav),
    .qst_sum_i(qst), .mask_wr_i(wr), .mask_wdata_i(wdata), .mask_rdata_o(mask_rd),
    .status_o(status), .poll_i(poll), .poll_byte_o(pbyte), .srq_n_o(srq_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // one clock: apply inputs at the falling edge, compare, advance the model
  task automatic step(input logic o, input logic e, input logic m, input logic q,
                      input logic w, input logic [7:0] d, input logic p, input logic r);
    logic mss;
    @(negedge clk);
    op = o; evt = e; mav = m; qst = q; wr = w; wdata = d; poll = p; rst = r;
    #1;
    mss = (o && m_mask[7]) || (e && m_mask[5]) || (m && m_mask[4]) || (q && m_mask[3]);
    if (!r) begin
      chk("R1 R3 R4 status byte", status, {o, mss, e, m, q, 3'b000});
      chk("R1 R6 poll byte", pbyte, {o, m_rqs, e, m, q, 3'b000});
      chk("R2 mask readback", mask_rd, m_mask);
      chk("R8 request pin", {7'd0, srq_n}, {7'd0, !m_rqs});
    end
    if (r) begin
      m_mask = '0; m_rqs = 1'b0; m_prev = 1'b0;
    end else begin
      if (w) m_mask = d & 8'hBF;
      if (mss && !m_prev) m_rqs = 1'b1;
      else if (p)         m_rqs = 1'b0;
      m_prev = mss;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset with inputs active
    step(1,1,1,1, 0,8'h00, 0, 1);
    step(1,1,1,1, 0,8'h00, 0, 1);
    step(1,1,1,1, 0,8'h00, 0, 0);   // R9 mask 0, flag 0, R3 summary 0
    // R2: bit 6 of written data is dropped
    step(0,0,0,0, 1,8'hFF, 0, 0);
    step(0,0,0,0, 0,8'h00, 0, 0);
    // R1: walk each source alone with full mask
    step(1,0,0,0, 0,8'h00, 0, 0);   // R5 rise
    step(0,0,0,0, 0,8'h00, 1, 0);   // R6 poll clears
    step(0,1,0,0, 0,8'h00, 0, 0);
    step(0,0,1,0, 0,8'h00, 1, 0);
    step(0,0,0,1, 0,8'h00, 1, 0);
    step(0,0,0,0, 0,8'h00, 1, 0);
    // R3: mask bit 6 and low bits give no summary
    step(0,0,0,0, 1,8'h47, 0, 0);
    step(1,1,1,1, 0,8'h00, 0, 0);
    step(1,1,1,1, 0,8'h00, 0, 0);
    // R3: only the questionable bit enabled
    step(1,1,1,0, 1,8'h08, 0, 0);
    step(1,1,1,0, 0,8'h00, 0, 0);
    step(0,0,0,1, 0,8'h00, 0, 0);   // R5 rise
    step(0,0,0,1, 0,8'h00, 0, 0);   // R4 reading clears nothing
    step(0,0,0,1, 1,8'h18, 1, 0);   // R6 poll while summary held
    step(0,0,1,1, 0,8'h00, 0, 0);   // R7 second source, no re-arm
    step(0,0,1,1, 0,8'h00, 0, 0);
    step(0,0,0,0, 0,8'h00, 0, 0);   // R7 summary falls
    step(0,0,1,0, 0,8'h00, 0, 0);   // R7 re-arm on new rise
    step(0,0,1,0, 0,8'h00, 1, 0);
    // R10: mask write makes summary rise in the poll cycle
    step(1,0,0,0, 1,8'h00, 0, 0);
    step(1,0,0,0, 1,8'h80, 0, 0);
    step(1,0,0,0, 0,8'h00, 1, 0);   // rise and poll on same edge
    step(1,0,0,0, 0,8'h00, 0, 0);   // flag must still be set
    step(1,0,0,0, 0,8'h00, 1, 0);
    step(1,0,0,0, 0,8'h00, 0, 0);
    // R9: reset mid-run with mask and flag set
    step(0,0,0,0, 0,8'h00, 0, 0);
    step(1,0,0,0, 0,8'h00, 0, 0);
    step(1,0,0,0, 0,8'h00, 0, 1);
    step(1,0,0,0, 0,8'h00, 0, 0);
    step(1,0,0,0, 0,8'h00, 0, 0);
    // pattern sweep over all source and mask combinations
    for (int k = 0; k < 256; k++) begin
      step(k[0], k[1], k[2], k[3], k[4], {k[7:5], k[3:0], 1'b0} ^ 8'h5A, k[5] & k[6], 0);
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule